// File: doc/BRIEF.md
# Retriggerable Clearable Pulse Stretcher

This block is a clocked, counter-based one-shot. Each valid trigger drives a high pulse of a programmed number of clock cycles on `pulse_o`, and `pulse_n_o` is always its complement. There are two trigger lines of opposite polarity. `trig_rise_i` fires on a rising edge, but only while `trig_fall_i` is high. `trig_fall_i` fires on a falling edge, but only while `trig_rise_i` is low. Tying the unused line to its enabling level selects either edge polarity from a single source.

A trigger that arrives during a pulse restarts the count, so the output stays high for the full period after the last accepted trigger. Setting parameter `NON_RETRIG` makes the block ignore triggers while its output is high. The active-low clear line `clear_n_i` overrides everything. It ends any pulse, and it blocks triggers while it is low and for a recovery window after it is released.

All three control lines pass through two-flop synchronisers, and edges are found on the synchronised values. The pulse length is taken from `period_cycles` at the moment a trigger is accepted.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A rising edge of `trig_rise_i` is accepted only while `trig_fall_i` is high and `clear_n_i` is high; a rising edge made while `trig_fall_i` is low produces no pulse.
- R2: A falling edge of `trig_fall_i` is accepted only while `trig_rise_i` is low and `clear_n_i` is high; a falling edge made while `trig_rise_i` is high produces no pulse.
- R3: After system reset, `pulse_o` is 0 and `pulse_n_o` is 1, and at every clock `pulse_n_o` equals the inverse of `pulse_o`.
- R4: An accepted trigger sets `pulse_o` high at the third rising clock edge after the trigger input changes (two synchroniser stages plus the output register), whatever the timer state.
- R5: An accepted trigger that arrives while `pulse_o` is high restarts the count, so `pulse_o` stays high until `period_cycles` cycles after the last accepted trigger.
- R6: With no further trigger, `pulse_o` is high for exactly P cycles, where P is the value of `period_cycles` when the trigger was accepted. A value of 0 gives a one-cycle pulse. Changing `period_cycles` during a pulse does not alter that pulse.
- R7: Driving `clear_n_i` low forces `pulse_o` low at the third rising clock edge after the change, even in the middle of a pulse.
- R8: While `clear_n_i` is low, trigger edges on either line leave `pulse_o` low.
- R9: After `clear_n_i` returns high, a trigger input change made fewer than `RECOVER_CYCLES` clock cycles after the release is ignored. One made `RECOVER_CYCLES` or more cycles after the release is accepted.
- R10: With `NON_RETRIG` set, triggers that arrive while `pulse_o` is high are ignored, and the pulse ends P cycles after the trigger that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| trig_rise_i | input | 1 | Rising-edge trigger, enabled by `trig_fall_i` high |
| trig_fall_i | input | 1 | Falling-edge trigger, enabled by `trig_rise_i` low |
| clear_n_i | input | 1 | Active-low pulse clear with recovery lockout |
| period_cycles | input | PERIOD_W (24) | Pulse length in cycles, taken when a trigger is accepted |
| pulse_o | output | 1 | One-shot output |
| pulse_n_o | output | 1 | Inverse of `pulse_o` |

## Verification
The assertions assume that the three control lines are asynchronous levels, each held for at least one clock. They also assume that `period_cycles` is stable from the trigger change until the pulse has started. The bench drives every input on the falling clock edge and holds it for several cycles. It arranges the enabling levels of the other trigger line while `clear_n_i` is low, so that preparing a vector never produces a stray trigger. It changes `period_cycles` only after the pulse has visibly started.

// File: rtl/osp_pkg.sv
package osp_pkg;

  // Synchronised view of the three control lines.
  typedef struct packed {
    logic rise_line;
    logic fall_line;
    logic clear_n;
  } osp_lines_t;

  // Rising edge of cur against its previous value, gated by an enable level.
  function automatic logic qual_rise(input logic cur, input logic prev,
                                     input logic enable);
    return cur & ~prev & enable;
  endfunction

  // Falling edge of cur against its previous value, gated by an enable level.
  function automatic logic qual_fall(input logic cur, input logic prev,
                                     input logic enable);
    return ~cur & prev & enable;
  endfunction

  // Width of a down-counter that must hold the value n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/osp_sync.sv
module osp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/osp_trig_detect.sv
module osp_trig_detect
  import osp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  osp_lines_t lines,
  output logic       rise_ok,
  output logic       fall_ok
);

  logic rise_prev;
  logic fall_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_prev <= 1'b0;
      fall_prev <= 1'b0;
    end else begin
      rise_prev <= lines.rise_line;
      fall_prev <= lines.fall_line;
    end
  end

  // A rising edge counts only with the other line high; a falling edge only with the other line low.
  assign rise_ok = qual_rise(lines.rise_line, rise_prev,
                             lines.fall_line & lines.clear_n);
  assign fall_ok = qual_fall(lines.fall_line, fall_prev,
                             ~lines.rise_line & lines.clear_n);

endmodule

// File: rtl/osp_lockout.sv
module osp_lockout
  import osp_pkg::*;
#(
  parameter int RECOVER_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_n_s,
  output logic locked
);

  localparam int RW = cnt_width(RECOVER_CYCLES);
  localparam logic [RW-1:0] LOAD = RW'(RECOVER_CYCLES);

  logic [RW-1:0] rec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rec_cnt <= LOAD;
    else if (!clear_n_s)       rec_cnt <= LOAD;
    else if (rec_cnt != '0)    rec_cnt <= rec_cnt - 1'b1;
  end

  assign locked = ~clear_n_s | (rec_cnt != '0);

endmodule

// File: rtl/osp_timer.sv
module osp_timer #(
  parameter int PERIOD_W   = 24,
  parameter bit NON_RETRIG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_n_s,
  input  logic                fire_req,
  input  logic [PERIOD_W-1:0] period,
  output logic                accept,
  output logic                pulse
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] elapsed;
  logic [PERIOD_W-1:0] length_q;

  // Pulse has run its length once the count reaches it (length 0 behaves as 1).
  function automatic logic run_done(input logic [PERIOD_W-1:0] cnt,
                                    input logic [PERIOD_W-1:0] len);
    return cnt >= len;
  endfunction

  if (NON_RETRIG) begin : g_nonretrig
    assign accept = fire_req & ~pulse;
  end else begin : g_retrig
    assign accept = fire_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse    <= 1'b0;
      elapsed  <= '0;
      length_q <= '0;
    end else if (!clear_n_s) begin
      pulse    <= 1'b0;
      elapsed  <= '0;
    end else if (accept) begin
      pulse    <= 1'b1;
      elapsed  <= ONE;
      length_q <= period;
    end else if (pulse) begin
      if (run_done(elapsed, length_q)) pulse   <= 1'b0;
      else                             elapsed <= elapsed + ONE;
    end
  end

endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import osp_pkg::*;
#(
  parameter int PERIOD_W       = 24,
  parameter int RECOVER_CYCLES = 4,
  parameter bit NON_RETRIG     = 1'b0,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_rise_i,
  input  logic                trig_fall_i,
  input  logic                clear_n_i,
  input  logic [PERIOD_W-1:0] period_cycles,
  output logic                pulse_o,
  output logic                pulse_n_o
);

  localparam int NLINES = $bits(osp_lines_t);

  osp_lines_t lines_s;
  logic       rise_ok;
  logic       fall_ok;
  logic       locked;
  logic       fire_req;
  logic       trig_fire;
  logic       clr_sync;
  logic       pulse_q;

  osp_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({trig_rise_i, trig_fall_i, clear_n_i}),
    .q     (lines_s)
  );

  assign clr_sync = lines_s.clear_n;

  osp_trig_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (lines_s),
    .rise_ok (rise_ok),
    .fall_ok (fall_ok)
  );

  osp_lockout #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_n_s (clr_sync),
    .locked    (locked)
  );

  assign fire_req = (rise_ok | fall_ok) & ~locked;

  osp_timer #(.PERIOD_W(PERIOD_W), .NON_RETRIG(NON_RETRIG)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_n_s (clr_sync),
    .fire_req  (fire_req),
    .period    (period_cycles),
    .accept    (trig_fire),
    .pulse     (pulse_q)
  );

  assign pulse_o   = pulse_q;
  assign pulse_n_o = ~pulse_q;

endmodule

// File: rtl/osp_checker.sv
module osp_checker (
  input logic clk,
  input logic rst_n,
  input logic pulse,
  input logic pulse_n,
  input logic clr_sync,
  input logic locked,
  input logic trig_fire
);

  // R3: outputs are always complementary
  p_complement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_n == !pulse);

  // R4: an accepted trigger sets the output on the next edge
  p_fire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> pulse);

  // R4: the output only rises after an accepted trigger
  p_rise_needs_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(trig_fire));

  // R7: a synchronised clear drives the output low
  p_clear_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_sync |=> !pulse);

  // R9: no new pulse starts during the lockout
  p_lockout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !$rose(pulse));

endmodule

bind oneshot_pulse_gen osp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pulse     (pulse_o),
  .pulse_n   (pulse_n_o),
  .clr_sync  (clr_sync),
  .locked    (locked),
  .trig_fire (trig_fire)
);

// File: tb/oneshot_pulse_gen_tb.sv
module oneshot_pulse_gen_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  REC        = 4;
  localparam int  NV         = 8;

  // Vector table: kind 0 = rising-line edge, 1 = falling-line edge;
  // other = level of the opposite line; width 0 = no pulse expected.
  localparam logic       V_KIND  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic       V_OTHER [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [23:0] V_PER  [NV] = '{24'd5, 24'd5, 24'd3, 24'd3, 24'd0, 24'd1, 24'd12, 24'd2};
  localparam int         V_WID   [NV] = '{5, 0, 3, 0, 1, 1, 12, 2};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_rise = 1'b0;
  logic        trig_fall = 1'b1;
  logic        clear_n = 1'b0;
  logic [23:0] period = 24'd0;
  logic        q, qn, q_nr, qn_nr;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_pulse_gen #(.PERIOD_W(24), .RECOVER_CYCLES(REC), .NON_RETRIG(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_rise_i(trig_rise), .trig_fall_i(trig_fall),
    .clear_n_i(clear_n), .period_cycles(period), .pulse_o(q), .pulse_n_o(qn));

  oneshot_pulse_gen #(.PERIOD_W(24), .RECOVER_CYCLES(REC), .NON_RETRIG(1'b1)) u_dut_nr (
    .clk(clk), .rst_n(rst_n), .trig_rise_i(trig_rise), .trig_fall_i(trig_fall),
    .clear_n_i(clear_n), .period_cycles(period), .pulse_o(q_nr), .pulse_n_o(qn_nr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Set line levels under clear, release, and wait out the recovery.
  task automatic prepare(input logic rise_lvl, input logic fall_lvl);
    @(negedge clk);
    clear_n = 1'b0;
    wait_neg(2);
    trig_rise = rise_lvl;
    trig_fall = fall_lvl;
    wait_neg(4);
    clear_n = 1'b1;
    wait_neg(REC + 6);
  endtask

  // Measure trigger-to-output delay and width of the main instance.
  task automatic measure(input int exp_w, input string tag);
    int  d = 0;
    int  w = 0;
    bit  comp_ok = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (qn != !q) comp_ok = 1'b0;
      if (q) begin d = i; break; end
    end
    if (exp_w == 0) begin
      chk(d == 0, {tag, " no pulse expected"}, d, 0);
    end else begin
      chk(d == 3, "R4 trigger-to-output delay", d, 3);
      w = 1;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (qn != !q) comp_ok = 1'b0;
        if (q) w++;
        else break;
      end
      chk(w == exp_w, {tag, " pulse width"}, w, exp_w);
    end
    chk(comp_ok, "R3 complement during vector", comp_ok, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    int cnt_nr;
    bit stay_low;

    wait_neg(3);
    // R3: reset state
    chk(q == 1'b0,  "R3 reset pulse_o",   q,  0);
    chk(qn == 1'b1, "R3 reset pulse_n_o", qn, 1);
    rst_n = 1'b1;
    wait_neg(2);
    clear_n = 1'b1;
    wait_neg(REC + 6);
    chk(q == 1'b0, "R3 idle after reset", q, 0);

    // Table walk: R1, R2, R6 (zero period gives one cycle)
    for (int v = 0; v < NV; v++) begin
      if (V_KIND[v] == 1'b0) prepare(1'b0, V_OTHER[v]);
      else                   prepare(V_OTHER[v], 1'b1);
      period = V_PER[v];
      if (V_KIND[v] == 1'b0) trig_rise = 1'b1;
      else                   trig_fall = 1'b0;
      measure(V_WID[v], (V_KIND[v] == 1'b0) ? "R1 R6" : "R2 R6");
    end

    // R5 and R10: retrigger during a pulse of 8
    prepare(1'b0, 1'b1);
    period = 24'd8;
    trig_rise = 1'b1;
    wait_neg(4);
    trig_rise = 1'b0;
    wait_neg(2);
    trig_rise = 1'b1;
    cnt = 0;
    cnt_nr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (q)    cnt++;
      if (q_nr) cnt_nr++;
    end
    chk(cnt == 10,   "R5 retrigger restarts count", cnt, 10);
    chk(cnt_nr == 4, "R10 non-retriggerable ignores retrigger", cnt_nr, 4);

    // R6: period change during a pulse has no effect
    prepare(1'b0, 1'b1);
    period = 24'd6;
    trig_rise = 1'b1;
    wait_neg(4);
    period = 24'd2;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      if (q) cnt++;
      @(negedge clk);
    end
    chk(cnt == 5, "R6 period sampled at trigger", cnt, 5);

    // R7: clear in the middle of a pulse
    prepare(1'b0, 1'b1);
    period = 24'd20;
    trig_rise = 1'b1;
    wait_neg(5);
    clear_n = 1'b0;
    wait_neg(2);
    chk(q == 1'b1, "R7 pulse still high two cycles after clear", q, 1);
    @(negedge clk);
    chk(q == 1'b0, "R7 pulse cut by clear", q, 0);

    // R8: triggers ignored while clear is low
    stay_low = 1'b1;
    trig_rise = 1'b0;
    wait_neg(2);
    trig_rise = 1'b1;
    wait_neg(3);
    trig_rise = 1'b0;
    wait_neg(3);
    trig_fall = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (q) stay_low = 1'b0;
    end
    chk(stay_low, "R8 no pulse while clear low", stay_low, 1);

    // R9: trigger too early after release is ignored
    trig_fall = 1'b1;
    trig_rise = 1'b0;
    period = 24'd3;
    wait_neg(3);
    clear_n = 1'b1;
    wait_neg(REC - 1);
    trig_rise = 1'b1;
    measure(0, "R9 early trigger");

    // R9: trigger exactly at the end of recovery is accepted
    clear_n = 1'b0;
    wait_neg(2);
    trig_rise = 1'b0;
    wait_neg(3);
    clear_n = 1'b1;
    wait_neg(REC);
    trig_rise = 1'b1;
    measure(3, "R9 trigger after recovery");

    finish_run();
  end

endmodule